// File: doc/BRIEF.md
# Byte AND execute unit

This unit carries out the byte-wide logical AND instruction family of a small CPU with eight 32-bit general registers. A fetched instruction of up to six bytes, left-aligned, is handed over on a valid/ready handshake. The unit decodes it, reads the register file through two combinational read ports, and writes one full 32-bit register back per write. Byte results are merged into the addressed lane, so the other bits of the register keep their values.

Register destinations complete in one execute cycle. Memory destinations are handled as a read-modify-write on a byte-wide request/response port: an optional address-register update, a read, one compute cycle, then a write to the same effective address. The unit also holds the condition-code register and the extended control register. It ANDs an immediate into either one, and it takes whole-register loads from the rest of the CPU on a control write port.

An 8-bit register operand is named by a 4-bit field. Bits 2:0 pick the 32-bit register. Bit 3 picks the lane: 1 means bits 7:0 and 0 means bits 15:8.

Top module: `byte_and_unit`

## Requirements
- R1: After reset, insn_ready is 1, mem_req_valid and rf_we are 0, ccr is 0x80 and exr is 0x87. An accepted instruction drops insn_ready on the next cycle, and insn_ready stays low until the instruction completes.
- R2: Bytes {0xE<d>, imm} AND imm into the 8-bit register d. Only that lane of the 32-bit register changes, and no other register changes.
- R3: Bytes {0x16, <s><d>} AND the 8-bit register s into the 8-bit register d. The source and destination may be the two lanes of the same register.
- R4: An AND to a register or to memory sets ccr bit 3 to result bit 7. It sets bit 2 when the result is zero and clears bit 1. Bit 0 and bits 7:4 of ccr are unchanged.
- R5: A memory-destination AND makes exactly one read and then exactly one write to the same address. A request holds its address, direction and data while mem_req_ready is low, and no new request is issued between a read handshake and its response.
- R6: Bytes {0x7D, <a>?, 0xE?, imm} AND imm into the memory byte at the address held in register a. Bytes {0x7D, <a>?, 0x16, <s>?} do the same with the 8-bit register s as the source. In both forms register a is unchanged.
- R7: Post-update forms access the original address and then leave register a holding that address plus one or minus one. The immediate forms are {0x01, 0x74 (+1) or 0x76 (-1), 0x6C, <a>?, 0xE?, imm}. The register forms are {0x01, 0x79, 0x8<a> (+1) or 0xA<a> (-1), 0x6<s>}.
- R8: Pre-update forms first step register a by one and then access the updated address. The immediate forms use second byte 0x75 (+1) or 0x77 (-1). The register forms use third byte 0x9<a> (+1) or 0xB<a> (-1).
- R9: When the source register is a lane of the address register, the AND uses the source value after the address update.
- R10: Bytes {0x06, imm} replace ccr with ccr AND imm.
- R11: Only exr bits 7 and 2:0 exist, and the other bits always read 0. A control write (ctl_wr_sel 0 = ccr, 1 = exr) loads the chosen register, with the exr value masked. Bytes {0x01, 0x41, 0x06, imm} AND imm into exr and leave ccr unchanged.
- R12: A byte pattern matching none of the forms is consumed and changes no register, no memory byte and no control register.
- R13: Address-register updates wrap modulo 2^32: 0 minus one gives 0xFFFFFFFF and 0xFFFFFFFF plus one gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction bytes valid |
| insn_ready | output | 1 | Unit idle, accepts an instruction |
| insn_bytes | input | 48 | Instruction bytes, first byte in bits 47:40 |
| rf_rd_a_idx | output | 3 | Register read port A index (destination or address register) |
| rf_rd_a_data | input | 32 | Register read port A data |
| rf_rd_b_idx | output | 3 | Register read port B index (source register) |
| rf_rd_b_data | input | 32 | Register read port B data |
| rf_we | output | 1 | Register write enable |
| rf_wr_idx | output | 3 | Register write index |
| rf_wr_data | output | 32 | Full 32-bit register write value |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address |
| mem_req_wdata | output | 8 | Write byte |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 8 | Read data byte |
| ctl_wr_en | input | 1 | Control register load strobe |
| ctl_wr_sel | input | 1 | 0 = ccr, 1 = exr |
| ctl_wr_data | input | 8 | Control register load value |
| ccr | output | 8 | Condition-code register |
| exr | output | 8 | Extended control register |

## Verification
The bench aims at the address-update cases. A design that swapped pre- and post-update would hit the neighbouring byte and leave the target alone. A design that read the source register too early would AND with the stale low byte of the address register when source and address share a register. Flag rules are checked with the carry flag and the upper ccr bits preset, so a design that cleared carry or rebuilt the whole ccr shows a wrong ccr value. Memory ready is stalled pseudo-randomly, and reads and writes are counted per instruction, so dropped or repeated accesses show up. Address wrap, the masked bits of exr and unrecognized byte patterns are each tested directly.

// File: rtl/byte_and_pkg.sv
package byte_and_pkg;
    localparam int BYTE_W     = 8;
    localparam int INSN_BYTES = 6;
    localparam int INSN_W     = INSN_BYTES * BYTE_W;
    localparam int NREG       = 8;
    localparam int RIDX_W     = $clog2(NREG);

    // condition-code bit positions
    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_V = 1;
    localparam int FLAG_C = 0;

    typedef enum logic [2:0] {K_NONE, K_REG, K_MEM, K_CCR, K_EXR} kind_e;
    typedef enum logic [2:0] {AM_IND, AM_POSTINC, AM_PREINC, AM_POSTDEC, AM_PREDEC} amode_e;
    typedef enum logic [2:0] {S_IDLE, S_EXEC, S_RD, S_RSP, S_CALC, S_WR} state_e;

    typedef struct packed {
        kind_e                kind;
        logic                 src_imm;
        logic [BYTE_W-1:0]    imm;
        logic [3:0]           src_nib;
        logic [3:0]           dst_nib;
        logic [RIDX_W-1:0]    areg;
        amode_e               amode;
    } dec_t;

    // two-bit step code shared by both auto-update encodings
    function automatic amode_e step_mode(input logic [1:0] code);
        case (code)
            2'd0:    return AM_POSTINC;
            2'd1:    return AM_PREINC;
            2'd2:    return AM_POSTDEC;
            default: return AM_PREDEC;
        endcase
    endfunction
endpackage

// File: rtl/bau_decode.sv
module bau_decode
    import byte_and_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output dec_t              dec_o
);
    logic [BYTE_W-1:0] b [INSN_BYTES];

    for (genvar i = 0; i < INSN_BYTES; i++) begin : g_split
        assign b[i] = insn_i[INSN_W-1-i*BYTE_W -: BYTE_W];
    end

    logic unused_tail;
    assign unused_tail = ^b[4][3:0];

    always_comb begin
        dec_o       = '0;
        dec_o.kind  = K_NONE;
        dec_o.amode = AM_IND;
        if (b[0][7:4] == 4'hE) begin
            dec_o.kind    = K_REG;
            dec_o.src_imm = 1'b1;
            dec_o.dst_nib = b[0][3:0];
            dec_o.imm     = b[1];
        end else if (b[0] == 8'h16) begin
            dec_o.kind    = K_REG;
            dec_o.src_nib = b[1][7:4];
            dec_o.dst_nib = b[1][3:0];
        end else if (b[0] == 8'h06) begin
            dec_o.kind = K_CCR;
            dec_o.imm  = b[1];
        end else if (b[0] == 8'h7D) begin
            dec_o.areg = b[1][6:4];
            if (b[2][7:4] == 4'hE) begin
                dec_o.kind    = K_MEM;
                dec_o.src_imm = 1'b1;
                dec_o.imm     = b[3];
            end else if (b[2] == 8'h16) begin
                dec_o.kind    = K_MEM;
                dec_o.src_nib = b[3][7:4];
            end
        end else if (b[0] == 8'h01) begin
            if (b[1] == 8'h41 && b[2] == 8'h06) begin
                dec_o.kind = K_EXR;
                dec_o.imm  = b[3];
            end else if (b[1][7:2] == 6'b0111_01 && b[2] == 8'h6C && b[4][7:4] == 4'hE) begin
                dec_o.kind    = K_MEM;
                dec_o.src_imm = 1'b1;
                dec_o.areg    = b[3][6:4];
                dec_o.amode   = step_mode(b[1][1:0]);
                dec_o.imm     = b[5];
            end else if (b[1] == 8'h79 && b[2][7:6] == 2'b10 && b[3][7:4] == 4'h6) begin
                dec_o.kind    = K_MEM;
                dec_o.areg    = b[2][2:0];
                dec_o.amode   = step_mode(b[2][5:4]);
                dec_o.src_nib = b[3][3:0];
            end
        end
    end
endmodule

// File: rtl/bau_addr_step.sv
module bau_addr_step
    import byte_and_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] base_i,
    input  amode_e        mode_i,
    output logic [AW-1:0] ea_o,
    output logic [AW-1:0] upd_o,
    output logic          upd_en_o
);
    logic [AW-1:0] plus1, minus1;
    assign plus1  = base_i + AW'(1);
    assign minus1 = base_i - AW'(1);

    always_comb begin
        ea_o     = base_i;
        upd_o    = base_i;
        upd_en_o = 1'b1;
        case (mode_i)
            AM_POSTINC: upd_o = plus1;
            AM_PREINC:  begin upd_o = plus1;  ea_o = plus1;  end
            AM_POSTDEC: upd_o = minus1;
            AM_PREDEC:  begin upd_o = minus1; ea_o = minus1; end
            default:    upd_en_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/bau_logic.sv
module bau_logic
    import byte_and_pkg::*;
(
    input  logic [BYTE_W-1:0] a_i,
    input  logic [BYTE_W-1:0] b_i,
    input  logic [7:0]        ccr_i,
    output logic [BYTE_W-1:0] res_o,
    output logic [7:0]        ccr_o
);
    always_comb begin
        res_o         = a_i & b_i;
        ccr_o         = ccr_i;
        ccr_o[FLAG_N] = res_o[BYTE_W-1];
        ccr_o[FLAG_Z] = (res_o == '0);
        ccr_o[FLAG_V] = 1'b0;
    end
endmodule

// File: rtl/byte_and_unit.sv
module byte_and_unit
    import byte_and_pkg::*;
#(
    parameter int         REG_W    = 32,
    parameter logic [7:0] EXR_IMPL = 8'h87,
    parameter logic [7:0] CCR_RST  = 8'h80,
    parameter logic [7:0] EXR_RST  = 8'h87
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 insn_valid,
    output logic                 insn_ready,
    input  logic [INSN_W-1:0]    insn_bytes,
    output logic [RIDX_W-1:0]    rf_rd_a_idx,
    input  logic [REG_W-1:0]     rf_rd_a_data,
    output logic [RIDX_W-1:0]    rf_rd_b_idx,
    input  logic [REG_W-1:0]     rf_rd_b_data,
    output logic                 rf_we,
    output logic [RIDX_W-1:0]    rf_wr_idx,
    output logic [REG_W-1:0]     rf_wr_data,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic                 mem_req_we,
    output logic [REG_W-1:0]     mem_req_addr,
    output logic [BYTE_W-1:0]    mem_req_wdata,
    input  logic                 mem_rsp_valid,
    input  logic [BYTE_W-1:0]    mem_rsp_data,
    input  logic                 ctl_wr_en,
    input  logic                 ctl_wr_sel,
    input  logic [7:0]           ctl_wr_data,
    output logic [7:0]           ccr,
    output logic [7:0]           exr
);
    localparam int LANE_W = 2 * BYTE_W;

    typedef struct packed {
        state_e             st;
        dec_t               dec;
        logic [REG_W-1:0]   addr;
        logic [BYTE_W-1:0]  mdata;
        logic [BYTE_W-1:0]  wdata;
        logic [7:0]         ccr;
        logic [7:0]         exr;
    } regs_t;

    regs_t q, d;

    function automatic logic [BYTE_W-1:0] lane_get(input logic [LANE_W-1:0] w, input logic lo);
        return lo ? w[BYTE_W-1:0] : w[LANE_W-1:BYTE_W];
    endfunction

    function automatic logic [REG_W-1:0] lane_put(input logic [REG_W-1:0] w, input logic lo,
                                                  input logic [BYTE_W-1:0] v);
        logic [REG_W-1:0] r;
        r = w;
        if (lo) r[BYTE_W-1:0]      = v;
        else    r[LANE_W-1:BYTE_W] = v;
        return r;
    endfunction

    dec_t              dec_in;
    logic [REG_W-1:0]  ea, upd;
    logic              upd_en;
    logic [BYTE_W-1:0] op_a, op_b, res;
    logic [7:0]        ccr_and;
    logic              unused_rdb;

    assign unused_rdb = ^rf_rd_b_data[REG_W-1:LANE_W];

    bau_decode u_dec (.insn_i(insn_bytes), .dec_o(dec_in));

    bau_addr_step #(.AW(REG_W)) u_step (
        .base_i  (rf_rd_a_data),
        .mode_i  (q.dec.amode),
        .ea_o    (ea),
        .upd_o   (upd),
        .upd_en_o(upd_en)
    );

    // operand A is the memory byte in CALC, else the destination lane
    assign op_a = (q.st == S_CALC) ? q.mdata : lane_get(rf_rd_a_data[LANE_W-1:0], q.dec.dst_nib[3]);
    assign op_b = q.dec.src_imm ? q.dec.imm : lane_get(rf_rd_b_data[LANE_W-1:0], q.dec.src_nib[3]);

    bau_logic u_logic (.a_i(op_a), .b_i(op_b), .ccr_i(q.ccr), .res_o(res), .ccr_o(ccr_and));

    always_comb begin
        d             = q;
        insn_ready    = (q.st == S_IDLE);
        rf_rd_a_idx   = (q.dec.kind == K_MEM) ? q.dec.areg : q.dec.dst_nib[RIDX_W-1:0];
        rf_rd_b_idx   = q.dec.src_nib[RIDX_W-1:0];
        rf_we         = 1'b0;
        rf_wr_idx     = q.dec.dst_nib[RIDX_W-1:0];
        rf_wr_data    = lane_put(rf_rd_a_data, q.dec.dst_nib[3], res);
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_addr  = q.addr;
        mem_req_wdata = q.wdata;

        case (q.st)
            S_IDLE: begin
                if (insn_valid) begin
                    d.dec = dec_in;
                    d.st  = S_EXEC;
                end
            end
            S_EXEC: begin
                d.st = S_IDLE;
                case (q.dec.kind)
                    K_REG: begin
                        rf_we = 1'b1;
                        d.ccr = ccr_and;
                    end
                    K_MEM: begin
                        rf_we      = upd_en;
                        rf_wr_idx  = q.dec.areg;
                        rf_wr_data = upd;
                        d.addr     = ea;
                        d.st       = S_RD;
                    end
                    K_CCR:   d.ccr = q.ccr & q.dec.imm;
                    K_EXR:   d.exr = q.exr & q.dec.imm & EXR_IMPL;
                    default: ;
                endcase
            end
            S_RD: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) d.st = S_RSP;
            end
            S_RSP: begin
                if (mem_rsp_valid) begin
                    d.mdata = mem_rsp_data;
                    d.st    = S_CALC;
                end
            end
            S_CALC: begin
                d.wdata = res;
                d.ccr   = ccr_and;
                d.st    = S_WR;
            end
            S_WR: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                if (mem_req_ready) d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase

        // loads from the rest of the CPU take precedence
        if (ctl_wr_en) begin
            if (ctl_wr_sel) d.exr = ctl_wr_data & EXR_IMPL;
            else            d.ccr = ctl_wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= S_IDLE;
            q.ccr   <= CCR_RST;
            q.exr   <= EXR_RST & EXR_IMPL;
        end else begin
            q <= d;
        end
    end

    assign ccr = q.ccr;
    assign exr = q.exr;

    // R5: a stalled request holds its fields
    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata));

    // R5: nothing new is requested while a read is outstanding
    a_r5_read_waits: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready && !mem_req_we |=> !mem_req_valid);

    // R1: acceptance makes the unit busy
    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        insn_valid && insn_ready |=> !insn_ready);

    // R4: register AND clears overflow, keeps carry
    a_r4_flag_rule: assert property (@(posedge clk) disable iff (!rst_n)
        q.st == S_EXEC && q.dec.kind == K_REG && !ctl_wr_en |=>
            !ccr[FLAG_V] && ccr[FLAG_C] == $past(ccr[FLAG_C]));

    // R11: AND into exr leaves ccr alone
    a_r11_exr_keeps_ccr: assert property (@(posedge clk) disable iff (!rst_n)
        q.st == S_EXEC && q.dec.kind == K_EXR && !ctl_wr_en |=> $stable(ccr));

    // R12: an unrecognized pattern writes no register
    a_r12_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        q.st == S_EXEC && q.dec.kind == K_NONE |-> !rf_we);
endmodule

// File: tb/byte_and_unit_tb.sv
module byte_and_unit_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic        insn_valid;
    logic        insn_ready;
    logic [47:0] insn_bytes;
    logic [2:0]  rf_rd_a_idx, rf_rd_b_idx, rf_wr_idx;
    logic [31:0] rf_rd_a_data, rf_rd_b_data, rf_wr_data;
    logic        rf_we;
    logic        mem_req_valid, mem_req_ready, mem_req_we;
    logic [31:0] mem_req_addr;
    logic [7:0]  mem_req_wdata;
    logic        mem_rsp_valid;
    logic [7:0]  mem_rsp_data;
    logic        ctl_wr_en, ctl_wr_sel;
    logic [7:0]  ctl_wr_data, ccr, exr;

    byte_and_unit u_dut (.*);

    // register file model with a preload port
    logic [31:0] rf [8];
    logic        pre_we;
    logic [2:0]  pre_idx;
    logic [31:0] pre_data;
    assign rf_rd_a_data = rf[rf_rd_a_idx];
    assign rf_rd_b_data = rf[rf_rd_b_idx];
    always @(posedge clk) begin
        if (rf_we) rf[rf_wr_idx] <= rf_wr_data;
        else if (pre_we) rf[pre_idx] <= pre_data;
    end

    // byte memory model with stalls
    logic [7:0] mem [16];
    logic       pre_mwe;
    logic [3:0] pre_midx;
    logic [7:0] pre_mdata;
    logic [7:0] lfsr = 8'h5B;
    always @(posedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    assign mem_req_ready = lfsr[1] | lfsr[4];
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_we) mem[mem_req_addr[3:0]] <= mem_req_wdata;
            else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem[mem_req_addr[3:0]];
            end
        end else if (pre_mwe) mem[pre_midx] <= pre_mdata;
    end

    // access monitor
    int n_rd = 0, n_wr = 0, n_bad = 0;
    logic [31:0] last_rd = '0;
    always @(posedge clk) begin
        if (mem_req_valid && mem_req_ready) begin
            if (!mem_req_we) begin
                n_rd    <= n_rd + 1;
                last_rd <= mem_req_addr;
            end else begin
                n_wr <= n_wr + 1;
                if (mem_req_addr != last_rd) n_bad <= n_bad + 1;
            end
        end
    end

    int checks = 0, fails = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_reg(input logic [2:0] i, input logic [31:0] v);
        @(negedge clk); pre_we = 1'b1; pre_idx = i; pre_data = v;
        @(negedge clk); pre_we = 1'b0;
    endtask

    task automatic set_mem(input logic [3:0] i, input logic [7:0] v);
        @(negedge clk); pre_mwe = 1'b1; pre_midx = i; pre_mdata = v;
        @(negedge clk); pre_mwe = 1'b0;
    endtask

    task automatic set_ctl(input logic sel, input logic [7:0] v);
        @(negedge clk); ctl_wr_en = 1'b1; ctl_wr_sel = sel; ctl_wr_data = v;
        @(negedge clk); ctl_wr_en = 1'b0;
    endtask

    task automatic run_insn(input logic [47:0] ins);
        while (!insn_ready) @(negedge clk);
        insn_bytes = ins; insn_valid = 1'b1;
        @(negedge clk);
        insn_valid = 1'b0;
        while (!insn_ready) @(negedge clk);
    endtask

    typedef struct packed {
        logic [31:0] tag;
        logic [47:0] ins;
        logic        ismem;
        logic [31:0] r0i, r1i;
        logic [7:0]  mi, ci;
        logic [31:0] r0e, r1e;
        logic [7:0]  me, ce;
    } vec_t;

    localparam logic [31:0] A = 32'hA5A5A5A5;
    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{"R2  ", 48'hE8AA_0000_0000, 1'b0, A, A, 8'hA5, 8'h00, 32'hA5A5A5A0, A, 8'hA5, 8'h08},
        '{"R4  ", 48'hE00F_0000_0000, 1'b0, A, A, 8'hA5, 8'h03, 32'hA5A505A5, A, 8'hA5, 8'h01},
        '{"R3  ", 48'h1608_0000_0000, 1'b0, 32'hA5A5AAA5, A, 8'hA5, 8'h00, 32'hA5A5AAA0, A, 8'hA5, 8'h08},
        '{"R4  ", 48'hE95A_0000_0000, 1'b0, A, A, 8'hA5, 8'hF8, A, 32'hA5A5A500, 8'hA5, 8'hF4},
        '{"R6  ", 48'h7D00_E0AA_0000, 1'b1, 32'h1005, A, 8'hA5, 8'h00, 32'h1005, A, 8'hA0, 8'h08},
        '{"R6  ", 48'h7D00_1690_0000, 1'b1, 32'h1005, 32'hA5A5A555, 8'hA5, 8'h00, 32'h1005, 32'hA5A5A555, 8'h05, 8'h00},
        '{"R7  ", 48'h0174_6C08_E055, 1'b1, 32'h1005, A, 8'hA5, 8'h01, 32'h1006, A, 8'h05, 8'h01},
        '{"R7  ", 48'h0176_6C08_E0AA, 1'b1, 32'h1005, A, 8'hA5, 8'h00, 32'h1004, A, 8'hA0, 8'h08},
        '{"R8  ", 48'h0175_6C08_E055, 1'b1, 32'h1004, A, 8'hA5, 8'h00, 32'h1005, A, 8'h05, 8'h00},
        '{"R8  ", 48'h0177_6C08_E0AA, 1'b1, 32'h1006, A, 8'hA5, 8'h00, 32'h1005, A, 8'hA0, 8'h08},
        '{"R7  ", 48'h0179_8069_0000, 1'b1, 32'h1005, 32'hA5A5A5AA, 8'hA5, 8'h00, 32'h1006, 32'hA5A5A5AA, 8'hA0, 8'h08},
        '{"R7  ", 48'h0179_A069_0000, 1'b1, 32'h1005, 32'hA5A5A555, 8'hA5, 8'h00, 32'h1004, 32'hA5A5A555, 8'h05, 8'h00},
        '{"R8  ", 48'h0179_9069_0000, 1'b1, 32'h1004, 32'hA5A5A5AA, 8'hA5, 8'h00, 32'h1005, 32'hA5A5A5AA, 8'hA0, 8'h08},
        '{"R8  ", 48'h0179_B069_0000, 1'b1, 32'h1006, 32'hA5A5A555, 8'hA5, 8'h00, 32'h1005, 32'hA5A5A555, 8'h05, 8'h00},
        '{"R9  ", 48'h0179_8068_0000, 1'b1, 32'h1005, A, 8'hA5, 8'h00, 32'h1006, A, 8'h04, 8'h00},
        '{"R9  ", 48'h0179_B068_0000, 1'b1, 32'h1006, A, 8'hA5, 8'h00, 32'h1005, A, 8'h05, 8'h00},
        '{"R10 ", 48'h06F7_0000_0000, 1'b0, A, A, 8'hA5, 8'hFF, A, A, 8'hA5, 8'hF7},
        '{"R10 ", 48'h06FE_0000_0000, 1'b0, A, A, 8'hA5, 8'h0F, A, A, 8'hA5, 8'h0E},
        '{"R12 ", 48'h5A12_0000_0000, 1'b0, A, A, 8'hA5, 8'h03, A, A, 8'hA5, 8'h03},
        '{"R4  ", 48'h7D00_E000_0000, 1'b1, 32'h1005, A, 8'hA5, 8'h08, 32'h1005, A, 8'h00, 8'h04},
        '{"R12 ", 48'h7D00_3300_0000, 1'b0, 32'h1005, A, 8'hA5, 8'h03, 32'h1005, A, 8'hA5, 8'h03}
    };

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; insn_valid = 1'b0; insn_bytes = '0;
        pre_we = 1'b0; pre_idx = '0; pre_data = '0;
        pre_mwe = 1'b0; pre_midx = '0; pre_mdata = '0;
        ctl_wr_en = 1'b0; ctl_wr_sel = 1'b0; ctl_wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 insn_ready", 32'(insn_ready), 32'd1);
        check("R1 mem_req_valid", 32'(mem_req_valid), 32'd0);
        check("R1 rf_we", 32'(rf_we), 32'd0);
        check("R1 ccr", 32'(ccr), 32'h80);
        check("R1 exr", 32'(exr), 32'h87);

        for (int i = 0; i < 8; i++) set_reg(3'(i), A);
        set_mem(4'd4, 8'h11);
        set_mem(4'd6, 8'h22);

        for (int v = 0; v < NV; v++) begin
            int rd0, wr0, bad0;
            logic others_ok;
            set_reg(3'd0, VEC[v].r0i);
            set_reg(3'd1, VEC[v].r1i);
            set_mem(4'd5, VEC[v].mi);
            set_ctl(1'b0, VEC[v].ci);
            rd0 = n_rd; wr0 = n_wr; bad0 = n_bad;
            run_insn(VEC[v].ins);
            @(negedge clk);
            check($sformatf("%s row %0d reg0", VEC[v].tag, v), rf[0], VEC[v].r0e);
            check($sformatf("%s row %0d reg1", VEC[v].tag, v), rf[1], VEC[v].r1e);
            check($sformatf("%s row %0d mem", VEC[v].tag, v), 32'(mem[5]), 32'(VEC[v].me));
            check($sformatf("%s row %0d ccr", VEC[v].tag, v), 32'(ccr), 32'(VEC[v].ce));
            others_ok = 1'b1;
            for (int r = 2; r < 8; r++) if (rf[r] !== A) others_ok = 1'b0;
            check($sformatf("%s row %0d other regs kept", VEC[v].tag, v), 32'(others_ok), 32'd1);
            // R5 access counts per instruction
            check($sformatf("R5 row %0d reads", v), 32'(n_rd - rd0), VEC[v].ismem ? 32'd1 : 32'd0);
            check($sformatf("R5 row %0d writes", v), 32'(n_wr - wr0), VEC[v].ismem ? 32'd1 : 32'd0);
            check($sformatf("R5 row %0d write address", v), 32'(n_bad - bad0), 32'd0);
        end
        check("R5 neighbour byte below", 32'(mem[4]), 32'h11);
        check("R5 neighbour byte above", 32'(mem[6]), 32'h22);

        // R11 exr masking and AND into exr
        set_ctl(1'b1, 8'hFF);
        check("R11 exr load masked", 32'(exr), 32'h87);
        set_ctl(1'b0, 8'h5A);
        run_insn(48'h0141_067F_0000);
        @(negedge clk);
        check("R11 exr and 7f", 32'(exr), 32'h07);
        check("R11 ccr untouched", 32'(ccr), 32'h5A);
        run_insn(48'h0141_0603_0000);
        @(negedge clk);
        check("R11 exr and 03", 32'(exr), 32'h03);
        run_insn(48'h0141_0600_0000);
        @(negedge clk);
        check("R11 exr and 00", 32'(exr), 32'h00);
        check("R11 ccr still untouched", 32'(ccr), 32'h5A);

        // R13 address wrap
        set_reg(3'd0, 32'h0);
        set_mem(4'd0, 8'h3C);
        set_mem(4'd15, 8'h99);
        run_insn(48'h0176_6C08_E0F0);
        @(negedge clk);
        check("R13 post-dec from zero reg", rf[0], 32'hFFFFFFFF);
        check("R13 post-dec from zero mem", 32'(mem[0]), 32'h30);
        run_insn(48'h0175_6C08_E00F);
        @(negedge clk);
        check("R13 pre-inc wrap reg", rf[0], 32'h0);
        check("R13 pre-inc wrap mem", 32'(mem[0]), 32'h00);
        check("R13 pre-inc wrap top byte kept", 32'(mem[15]), 32'h99);
        run_insn(48'h0177_6C08_E0F0);
        @(negedge clk);
        check("R13 pre-dec wrap reg", rf[0], 32'hFFFFFFFF);
        check("R13 pre-dec wrap mem", 32'(mem[15]), 32'h90);

        summary();
        $finish;
    end
endmodule